// File: doc/BRIEF.md
# Successive Approximation Converter Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter. Software programs it through a small write port: a configuration register holds the enable, the 4-bit input channel, the conversion clock choice and the start bit, and a mode register holds the result format, the two reference selects and the interrupt enable. A third address clears the completion flag. The analog input multiplexer, the DAC and the comparator are outside the block. The block drives the channel code, the sample switch control and the 10-bit trial code. It reads back one comparator bit.

A conversion takes a fixed frame of 11 bit periods. The bit period comes from the system clock divided by 2, 8 or 32, or from the rising edges of a separate, asynchronous RC clock. The first period sets up the conversion. Each later period resolves one result bit, most significant first. At the end the block loads two 8-bit result registers, left or right justified. In the same cycle it clears its busy/start bit, sets the completion flag and closes the sample switch.

Top module: `sar_adc_seq`

## Requirements
- R1: After a synchronous reset, busy, done_flag and irq are 0, res_hi and res_lo are 0, dac_code is 0 and sample_closed is 1.
- R2: A write to address 0 with bit 0 (enable) and bit 7 (start) both 1 begins a conversion when none is running. The busy output, which is the start bit, reads 1 until the conversion ends.
- R3: Address 0 bits [6:5] choose the bit period: 00 = 2 system clocks, 01 = 8, 10 = 32, 11 = RC clock. In the divided modes busy stays high for exactly 11 bit periods, which is 11 times the divider in system clock cycles.
- R4: The result is built most significant bit first. A trial bit is kept when cmp_hi is 1 (held input above the DAC level) and cleared otherwise. With a comparator that reports input code >= dac_code, the result equals the input code.
- R5: In the cycle the conversion ends, busy clears, done_flag sets, sample_closed sets and both result registers load together. The result registers do not change while a conversion runs.
- R6: With address 1 bit 0 at 1, the result is right justified: res_hi = {6'b0, r[9:8]} and res_lo = r[7:0]. With it at 0, the result is left justified: res_hi = r[9:2] and res_lo = {r[1:0], 6'b0}. The format in force when the result is loaded applies.
- R7: done_flag is set after every completed conversion whatever the interrupt enable. irq is done_flag AND address 1 bit 3. Only a write to address 2 clears done_flag. If a completion and a clear fall in the same cycle, the completion wins.
- R8: sample_closed is 0 from the start of a conversion until its result is loaded, and 1 otherwise.
- R9: chan_sel follows address 0 bits [4:1] directly (codes 0 to 13 for the analog inputs, 14 for the comparator reference, 15 for the fixed reference). vref_pos_ext follows address 1 bit 1 and vref_neg_ext follows address 1 bit 2.
- R10: A write to address 0 with bit 0 at 0 during a conversion aborts it. busy clears and sample_closed sets on that edge, the result registers keep their values, and done_flag is not set.
- R11: A start request written while bit 0 of the same write is 0 is ignored. No conversion starts and done_flag does not change.
- R12: In RC mode, rc_clk passes through a two-flop synchronizer and each synchronized rising edge is one bit-period tick. The conversion completes with a correct result.
- R13: During the setup period dac_code is 0. From the first tick on, dac_code holds the bits already decided with the bit under trial set and the lower bits clear. The first trial is 10'h200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 configuration, 1 mode, 2 flag clear |
| wr_data | input | 8 | Register write data |
| rc_clk | input | 1 | Asynchronous RC conversion clock |
| cmp_hi | input | 1 | Comparator: 1 when the held input is above the DAC level |
| busy | output | 1 | Start bit, reads 1 while a conversion runs |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Completion flag gated by the interrupt enable |
| res_hi | output | 8 | High result register |
| res_lo | output | 8 | Low result register |
| chan_sel | output | 4 | Analog multiplexer select |
| vref_pos_ext | output | 1 | Positive reference select: 1 external, 0 supply |
| vref_neg_ext | output | 1 | Negative reference select: 1 external, 0 ground |
| sample_closed | output | 1 | Sample switch control: 1 closed (tracking) |
| dac_code | output | 10 | Trial code to the DAC |

## Verification
The bench builds the block with its default parameters: a 10-bit result, dividers of 2, 8 and 32 and a two-stage synchronizer. With these dividers a full frame lasts at most 352 cycles. That leaves room for many random input codes in every format, together with the code extremes 0, 1023, 511 and 512, and an exact frame-length check in each divided mode. The RC clock runs at a period that is not a whole multiple of the system clock. The synchronizer and edge detector therefore see truly unaligned edges, and abort and ignored-start cases can be placed at chosen points of a long /32 frame.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {
    CLK_DIV_A = 2'b00,
    CLK_DIV_B = 2'b01,
    CLK_DIV_C = 2'b10,
    CLK_RC    = 2'b11
  } clk_sel_e;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/sar_tick_gen.sv
// Bit-period tick source: divided system clock or synchronized RC edges.
module sar_tick_gen
  import sar_adc_pkg::*;
#(
  parameter int DIV_A       = 2,
  parameter int DIV_B       = 8,
  parameter int DIV_C       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     restart,
  input  clk_sel_e sel,
  input  logic     rc_clk,
  output logic     tick
);
  localparam int DMAX_AB = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int DMAX    = (DMAX_AB > DIV_C) ? DMAX_AB : DIV_C;
  localparam int CW      = $clog2(DMAX + 1);

  logic [CW-1:0]          cnt_q;
  logic [CW-1:0]          limit;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rc_prev_q;
  logic                   rc_rise;

  always_comb begin
    case (sel)
      CLK_DIV_A: limit = CW'(DIV_A - 1);
      CLK_DIV_B: limit = CW'(DIV_B - 1);
      CLK_DIV_C: limit = CW'(DIV_C - 1);
      default:   limit = '0;
    endcase
  end

  // synchronizer chain for the asynchronous RC clock
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= rc_clk;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rc_prev_q <= 1'b0;
    else     rc_prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rc_rise = sync_q[SYNC_STAGES-1] & ~rc_prev_q;

  // divider restarts with every conversion so the frame length is exact
  always_ff @(posedge clk) begin
    if (rst || restart)  cnt_q <= '0;
    else if (run)        cnt_q <= (cnt_q == limit) ? '0 : cnt_q + CW'(1);
  end

  assign tick = run && ((sel == CLK_RC) ? rc_rise : (cnt_q == limit));
endmodule

// File: rtl/sar_core.sv
// Eleven-period successive approximation sequence, MSB first.
module sar_core #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp_hi,
  output logic             busy,
  output logic             sample_closed,
  output logic [RES_W-1:0] dac_code,
  output logic             finish,
  output logic [RES_W-1:0] final_code
);
  localparam int SW = $clog2(RES_W + 1);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic             busy_q;
  logic             closed_q;
  logic [SW-1:0]    step_q;
  logic [RES_W-1:0] code_q;
  logic [RES_W-1:0] trial_mask;
  logic [RES_W-1:0] decided;
  logic [RES_W-1:0] next_trial;

  // step 0 is setup; step k (1..RES_W) resolves bit RES_W-k
  assign trial_mask = TOP_BIT >> (step_q - SW'(1));
  assign decided    = cmp_hi ? code_q : (code_q & ~trial_mask);
  assign next_trial = decided | (trial_mask >> 1);
  assign finish     = busy_q && tick && (step_q == SW'(RES_W));
  assign final_code = decided;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      closed_q <= 1'b1;
      step_q   <= '0;
      code_q   <= '0;
    end else if (abort && busy_q) begin
      busy_q   <= 1'b0;
      closed_q <= 1'b1;
      step_q   <= '0;
      code_q   <= '0;
    end else if (go && !busy_q) begin
      busy_q   <= 1'b1;
      closed_q <= 1'b0;
      step_q   <= '0;
      code_q   <= '0;
    end else if (busy_q && tick) begin
      if (step_q == '0) begin
        code_q <= TOP_BIT;
        step_q <= SW'(1);
      end else if (finish) begin
        busy_q   <= 1'b0;
        closed_q <= 1'b1;
        step_q   <= '0;
        code_q   <= '0;
      end else begin
        code_q <= next_trial;
        step_q <= step_q + SW'(1);
      end
    end
  end

  assign busy          = busy_q;
  assign sample_closed = closed_q;
  assign dac_code      = code_q;
endmodule

// File: rtl/sar_result_reg.sv
// Result register pair; justification is applied at load time.
module sar_result_reg #(
  parameter int RES_W = 10,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             right_just,
  input  logic [RES_W-1:0] code,
  output logic [OUT_W-1:0] hi,
  output logic [OUT_W-1:0] lo
);
  localparam int TOT = 2 * OUT_W;
  localparam int PAD = TOT - RES_W;

  logic [TOT-1:0] packed_word;

  assign packed_word = right_just ? TOT'(code) : (TOT'(code) << PAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= '0;
      lo <= '0;
    end else if (load) begin
      hi <= packed_word[TOT-1:OUT_W];
      lo <= packed_word[OUT_W-1:0];
    end
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int OUT_W       = 8,
  parameter int DIV_A       = 2,
  parameter int DIV_B       = 8,
  parameter int DIV_C       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             rc_clk,
  input  logic             cmp_hi,
  output logic             busy,
  output logic             done_flag,
  output logic             irq,
  output logic [OUT_W-1:0] res_hi,
  output logic [OUT_W-1:0] res_lo,
  output logic [3:0]       chan_sel,
  output logic             vref_pos_ext,
  output logic             vref_neg_ext,
  output logic             sample_closed,
  output logic [RES_W-1:0] dac_code
);
  logic       en_q;
  logic [3:0] chan_q;
  clk_sel_e   sel_q;
  logic       fmt_q;
  logic       pref_q;
  logic       nref_q;
  logic       irqen_q;
  logic       flag_q;

  logic cfg_wr, mode_wr, flag_wr;
  logic go, abort, tick, finish, busy_w;
  logic [RES_W-1:0] final_code;

  assign cfg_wr  = wr_en && (wr_addr == ADDR_CFG);
  assign mode_wr = wr_en && (wr_addr == ADDR_MODE);
  assign flag_wr = wr_en && (wr_addr == ADDR_FLAG);
  assign go      = cfg_wr && wr_data[0] && wr_data[7] && !busy_w;
  assign abort   = cfg_wr && !wr_data[0] && busy_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      chan_q  <= '0;
      sel_q   <= CLK_DIV_A;
      fmt_q   <= 1'b0;
      pref_q  <= 1'b0;
      nref_q  <= 1'b0;
      irqen_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        en_q   <= wr_data[0];
        chan_q <= wr_data[4:1];
        sel_q  <= clk_sel_e'(wr_data[6:5]);
      end
      if (mode_wr) begin
        fmt_q   <= wr_data[0];
        pref_q  <= wr_data[1];
        nref_q  <= wr_data[2];
        irqen_q <= wr_data[3];
      end
    end
  end

  // completion sets the flag; a flag write clears it; set has priority
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (finish)  flag_q <= 1'b1;
    else if (flag_wr) flag_q <= 1'b0;
  end

  sar_tick_gen #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .SYNC_STAGES(SYNC_STAGES)
  ) u_tick (
    .clk(clk), .rst(rst), .run(busy_w), .restart(go),
    .sel(sel_q), .rc_clk(rc_clk), .tick(tick)
  );

  sar_core #(.RES_W(RES_W)) u_core (
    .clk(clk), .rst(rst), .go(go), .abort(abort), .tick(tick),
    .cmp_hi(cmp_hi), .busy(busy_w), .sample_closed(sample_closed),
    .dac_code(dac_code), .finish(finish), .final_code(final_code)
  );

  sar_result_reg #(.RES_W(RES_W), .OUT_W(OUT_W)) u_res (
    .clk(clk), .rst(rst), .load(finish), .right_just(fmt_q),
    .code(final_code), .hi(res_hi), .lo(res_lo)
  );

  assign busy         = busy_w;
  assign done_flag    = flag_q;
  assign irq          = flag_q & irqen_q;
  assign chan_sel     = chan_q;
  assign vref_pos_ext = pref_q;
  assign vref_neg_ext = nref_q;
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done_flag,
  input logic             irq,
  input logic             sample_closed,
  input logic [OUT_W-1:0] res_hi,
  input logic [OUT_W-1:0] res_lo,
  input logic             en_q,
  input logic             fmt_q
);
  assert_switch_open_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sample_closed);

  assert_finish_together_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> ($fell(busy) && $rose(sample_closed)));

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> ($stable(res_hi) && $stable(res_lo)));

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_flag);

  assert_right_pad_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(done_flag) && $past(fmt_q)) |-> (res_hi[OUT_W-1:2] == '0));

  assert_left_pad_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(done_flag) && !$past(fmt_q)) |-> (res_lo[OUT_W-3:0] == '0));

  assert_busy_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> en_q);
endmodule

bind sar_adc_seq sar_adc_seq_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done_flag(done_flag), .irq(irq),
  .sample_closed(sample_closed), .res_hi(res_hi), .res_lo(res_lo),
  .en_q(en_q), .fmt_q(fmt_q)
);

// File: tb/sar_adc_seq_bench.sv
`timescale 1ns/1ps
module sar_adc_seq_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rc_clk = 1'b0;
  logic       cmp_hi;
  logic       busy, done_flag, irq, vref_pos_ext, vref_neg_ext, sample_closed;
  logic [7:0] res_hi, res_lo;
  logic [3:0] chan_sel;
  logic [9:0] dac_code;
  logic [9:0] vin = '0;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2 clk = ~clk;
  always #37 rc_clk = ~rc_clk;

  // comparator model: input sits half an LSB above its code
  assign cmp_hi = (vin >= dac_code);

  sar_adc_seq u_sar_adc_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rc_clk(rc_clk), .cmp_hi(cmp_hi), .busy(busy), .done_flag(done_flag),
    .irq(irq), .res_hi(res_hi), .res_lo(res_lo), .chan_sel(chan_sel),
    .vref_pos_ext(vref_pos_ext), .vref_neg_ext(vref_neg_ext),
    .sample_closed(sample_closed), .dac_code(dac_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_hi(input int v, input bit right);
    return right ? (v >> 8) : (v >> 2);
  endfunction

  function automatic int exp_lo(input int v, input bit right);
    return right ? (v & 255) : ((v & 3) << 6);
  endfunction

  function automatic int div_of(input int sel);
    return (sel == 0) ? 2 : (sel == 1) ? 8 : 32;
  endfunction

  // one write; returns at the falling edge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic convert(input int v, input int sel, input bit right, input int ch);
    int n;
    vin = v[9:0];
    wr(2'd1, {7'b0, right});
    wr(2'd2, 8'h00);
    wr(2'd0, {1'b1, sel[1:0], ch[3:0], 1'b1});
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(sample_closed == 1'b0, "R8 switch open", sample_closed, 0);
    wait_idle(n);
    if (sel != 3)
      chk(n == 11 * div_of(sel), "R3 frame length", n, 11 * div_of(sel));
    else
      chk(n > 0 && n < 5000, "R12 rc frame done", n, 1);
    chk(done_flag == 1'b1, "R5 flag at end", done_flag, 1);
    chk(sample_closed == 1'b1, "R8 switch closed", sample_closed, 1);
    chk(res_hi == exp_hi(v, right), "R4 R6 res_hi", res_hi, exp_hi(v, right));
    chk(res_lo == exp_lo(v, right), "R4 R6 res_lo", res_lo, exp_lo(v, right));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done_flag == 0 && irq == 0, "R1 status", {busy, done_flag, irq}, 0);
    chk(res_hi == 0 && res_lo == 0, "R1 results", {res_hi, res_lo}, 0);
    chk(sample_closed == 1 && dac_code == 0, "R1 switch/dac", {sample_closed, dac_code}, 1024);

    // R9 channel and reference selects
    wr(2'd0, {3'b000, 4'd13, 1'b1});
    chk(chan_sel == 4'd13 && busy == 0, "R9 chan 13", chan_sel, 13);
    wr(2'd0, {3'b000, 4'd15, 1'b1});
    chk(chan_sel == 4'd15, "R9 chan 15", chan_sel, 15);
    wr(2'd1, 8'b0000_0110);
    chk(vref_pos_ext == 1 && vref_neg_ext == 1, "R9 refs on", {vref_pos_ext, vref_neg_ext}, 3);
    wr(2'd1, 8'b0000_0010);
    chk(vref_pos_ext == 1 && vref_neg_ext == 0, "R9 pos only", {vref_pos_ext, vref_neg_ext}, 2);

    // R13 trial code timing with divider 2
    vin = 10'd300;
    wr(2'd2, 8'h00);
    wr(2'd0, {1'b1, 2'b00, 4'd2, 1'b1});
    @(negedge clk);
    chk(dac_code == 0, "R13 setup dac", dac_code, 0);
    @(negedge clk);
    chk(dac_code == 10'h200, "R13 first trial", dac_code, 512);
    repeat (2) @(negedge clk);
    chk(dac_code == 10'h100, "R13 second trial", dac_code, 256);
    wait_idle(n);
    chk(res_hi == exp_hi(300, 0), "R4 after trial check", res_hi, exp_hi(300, 0));

    // directed code extremes
    convert(0, 0, 1'b1, 3);
    convert(1023, 1, 1'b1, 4);
    convert(1023, 2, 1'b0, 5);
    convert(512, 0, 1'b0, 0);
    convert(511, 1, 1'b1, 14);

    // R7 flag set with irq disabled, then irq gating and clear
    chk(done_flag == 1 && irq == 0, "R7 flag without irq", {done_flag, irq}, 2);
    wr(2'd1, 8'b0000_1001);
    chk(irq == 1, "R7 irq enabled", irq, 1);
    wr(2'd1, 8'b0000_1001);
    chk(done_flag == 1, "R7 flag held by mode write", done_flag, 1);
    wr(2'd2, 8'h00);
    chk(done_flag == 0 && irq == 0, "R7 flag cleared", {done_flag, irq}, 0);

    // R10 abort mid conversion, results from the 511 run must remain
    wr(2'd1, 8'b0000_0001);
    vin = 10'd77;
    wr(2'd0, {1'b1, 2'b10, 4'd1, 1'b1});
    repeat (50) @(negedge clk);
    chk(busy == 1, "R10 running before abort", busy, 1);
    wr(2'd0, {1'b0, 2'b10, 4'd1, 1'b0});
    chk(busy == 0 && sample_closed == 1, "R10 stopped", {busy, sample_closed}, 1);
    repeat (400) @(negedge clk);
    chk(done_flag == 0, "R10 no flag", done_flag, 0);
    chk(res_hi == exp_hi(511, 1) && res_lo == exp_lo(511, 1), "R10 results kept",
        {res_hi, res_lo}, {exp_hi(511, 1), exp_lo(511, 1)});

    // R11 start while disabled
    wr(2'd0, {1'b1, 2'b00, 4'd6, 1'b0});
    chk(busy == 0 && sample_closed == 1, "R11 no start", {busy, sample_closed}, 1);
    repeat (100) @(negedge clk);
    chk(done_flag == 0 && busy == 0, "R11 no flag", {done_flag, busy}, 0);

    // R12 RC clock mode
    convert(700, 3, 1'b1, 7);
    convert(3, 3, 1'b0, 8);

    // random conversions in divided modes
    for (int i = 0; i < 24; i++) begin
      int v, s;
      bit f;
      v = $urandom % 1024;
      s = $urandom % 3;
      f = $urandom % 2;
      convert(v, s, f, $urandom % 16);
    end

    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule